// File: doc/BRIEF.md
# Trapdoor Configuration Unlock for a Drive Register Window

This block sits between a host register bus and the task-file register window of a parallel disk channel. In normal operation every access is passed straight through to the drive port. A handful of hidden timing and control registers share the same small offset range. They are reached only after a particular access pattern on the ordinary drive offsets. That pattern is two back-to-back word reads of offset 1, followed by a byte write of 0x03 to offset 2.

Once that pattern has been seen, the window is in configuration mode. Byte writes land in the hidden registers and reads return their contents. Nothing reaches the drive. A byte write of 0x83 to offset 2 closes the window again. Any access that breaks the pattern before it completes sends the tracker back to its start. The hidden register contents drive the timing outputs of the channel.

One hidden register reports which of two bus clock rates the board uses. Bit 0 of that register comes from a strap pin, which is sampled while reset is held.

Top module: `cfg_trapdoor`

## Requirements
- R1: While reset is asserted, and after its release, configuration mode is off and every hidden register reads as zero, except bit 0 of the strap register.
- R2: Configuration mode turns on in the cycle after a byte write of 0x03 to offset 2. That write must immediately follow two consecutive word reads of offset 1.
- R3: The unlock tracker returns to idle on any access that does not continue the pattern. Examples are a byte-size read of offset 1, a write to offset 2 of a value other than 0x03, or a word-size write to offset 2. A later lone 0x03 write then does not unlock.
- R4: The word reads of offset 1 that make up the pattern are forwarded to the drive: the drive read strobe is high and the host read data equals the drive read data.
- R5: In configuration mode, a byte write stores its low 8 bits in a hidden register. Offset 0 is read-cycle timing, 1 is write-cycle timing, 3 is control and 6 is miscellaneous. The stored value appears on the matching output from the next cycle.
- R6: The strap register sits at offset 5. Its bit 0 is the strap pin value captured during reset and holds that value afterwards. Its bits 7:1 can be written in configuration mode.
- R7: In configuration mode, a read of any width returns the addressed hidden register, zero-extended to 16 bits. Offsets 2, 4 and 7 read as zero, and the read is not forwarded.
- R8: In configuration mode, a byte write of 0x83 to offset 2 turns configuration mode off from the next cycle. Later reads are forwarded again, and hidden register contents are kept.
- R9: In configuration mode, the following writes change no hidden register and leave the window unlocked: word-size writes, byte writes to offsets 2, 4 and 7, and byte writes to offset 2 of any value but 0x83.
- R10: The completing unlock write and the relock write are never forwarded to the drive. No access made in configuration mode raises a drive strobe.
- R11: Outside configuration mode, every write (other than the completing unlock write) raises the drive write strobe in the same cycle and changes no hidden register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_pin | input | 1 | Bus clock rate strap, captured during reset |
| hb_addr | input | 3 | Register offset within the window |
| hb_wide | input | 1 | Access size: 1 = 16-bit word, 0 = byte |
| hb_rd | input | 1 | Read strobe, one cycle per access |
| hb_wr | input | 1 | Write strobe, one cycle per access |
| hb_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| hb_rdata | output | 16 | Read data to the host |
| drv_rd | output | 1 | Read strobe passed through to the drive port |
| drv_wr | output | 1 | Write strobe passed through to the drive port |
| drv_rdata | input | 16 | Read data from the drive port |
| cfg_mode | output | 1 | High while the window is unlocked |
| rd_timing | output | 8 | Read-cycle timing register |
| wr_timing | output | 8 | Write-cycle timing register |
| ctrl_reg | output | 8 | Control register |
| strap_reg | output | 8 | Strap register (bit 0 = sampled strap) |
| misc_reg | output | 8 | Miscellaneous register |

## Verification
The properties assume that each bus access lasts exactly one cycle, that read and write strobes are never high together, and that reset is held for at least two cycles. Under these assumptions every clock edge that carries a strobe is one distinct access to the pattern tracker. The stimulus gives each access its own cycle with a single strobe, drops the strobes between vectors, and applies reset for several cycles both times. Write data above bit 7 is used only for word writes, which the block must ignore while unlocked.

// File: rtl/cfg_trapdoor_pkg.sv
package cfg_trapdoor_pkg;

    // Progress of the unlock pattern; KN_OPEN means configuration mode.
    typedef enum logic [1:0] {
        KN_IDLE = 2'd0,
        KN_ARM1 = 2'd1,
        KN_ARM2 = 2'd2,
        KN_OPEN = 2'd3
    } knock_st_e;

endpackage

// File: rtl/cfg_knock_fsm.sv
module cfg_knock_fsm
    import cfg_trapdoor_pkg::*;
#(
    parameter int                ADDR_W       = 3,
    parameter int                REG_W        = 8,
    parameter int                KNOCK_RD_OFF = 1,
    parameter int                KNOCK_WR_OFF = 2,
    parameter logic [REG_W-1:0]  UNLOCK_VAL   = 8'h03,
    parameter logic [REG_W-1:0]  RELOCK_VAL   = 8'h83
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic              hb_wide,
    input  logic              hb_rd,
    input  logic              hb_wr,
    input  logic [REG_W-1:0]  wbyte,
    output logic              cfg_mode,
    output logic              swallow
);

    localparam logic [ADDR_W-1:0] RD_A = ADDR_W'(KNOCK_RD_OFF);
    localparam logic [ADDR_W-1:0] WR_A = ADDR_W'(KNOCK_WR_OFF);

    typedef struct packed {
        knock_st_e st;
    } fsm_s_t;

    fsm_s_t s_d, s_q;

    logic any_acc;
    logic knock_rd;
    logic unlock_wr;
    logic relock_wr;

    // A write strobe takes priority when both strobes are high.
    assign any_acc   = hb_rd | hb_wr;
    assign knock_rd  = hb_rd & ~hb_wr & hb_wide & (hb_addr == RD_A);
    assign unlock_wr = hb_wr & ~hb_wide & (hb_addr == WR_A) & (wbyte == UNLOCK_VAL);
    assign relock_wr = hb_wr & ~hb_wide & (hb_addr == WR_A) & (wbyte == RELOCK_VAL);

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.st = KN_IDLE;
        end else begin
            case (s_q.st)
                KN_IDLE: begin
                    if (knock_rd) s_d.st = KN_ARM1;
                end
                KN_ARM1: begin
                    if (knock_rd)     s_d.st = KN_ARM2;
                    else if (any_acc) s_d.st = KN_IDLE;
                end
                KN_ARM2: begin
                    if (unlock_wr)    s_d.st = KN_OPEN;
                    else if (any_acc) s_d.st = KN_IDLE;
                end
                KN_OPEN: begin
                    if (relock_wr) s_d.st = KN_IDLE;
                end
                default: s_d.st = KN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cfg_mode = (s_q.st == KN_OPEN);
    assign swallow  = (s_q.st == KN_ARM2) & unlock_wr;

endmodule

// File: rtl/cfg_hidden_regs.sv
module cfg_hidden_regs #(
    parameter int          ADDR_W    = 3,
    parameter int          REG_W     = 8,
    parameter int          STRAP_OFF = 5,
    parameter int unsigned IMPL_MASK = 32'h0000_006B
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              strap_pin,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [REG_W-1:0]                  wbyte,
    output logic [(1<<ADDR_W)-1:0][REG_W-1:0] view
);

    localparam int N_OFF = 1 << ADDR_W;

    typedef struct packed {
        logic [N_OFF-1:0][REG_W-1:0] regs;
        logic                        strap;
    } hid_s_t;

    hid_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.regs  = '0;
            s_d.strap = strap_pin;
        end else if (wr_en) begin
            for (int i = 0; i < N_OFF; i++) begin
                if (IMPL_MASK[i] && (wr_addr == ADDR_W'(i))) begin
                    // Bit 0 of the strap register is not storage.
                    if (i == STRAP_OFF) s_d.regs[i] = {wbyte[REG_W-1:1], 1'b0};
                    else                s_d.regs[i] = wbyte;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    for (genvar g = 0; g < N_OFF; g++) begin : g_view
        if (g == STRAP_OFF) begin : g_strap
            assign view[g] = s_q.regs[g] | {{(REG_W-1){1'b0}}, s_q.strap};
        end else begin : g_plain
            // Unimplemented entries are never written and stay zero.
            assign view[g] = s_q.regs[g];
        end
    end

endmodule

// File: rtl/cfg_bus_steer.sv
module cfg_bus_steer #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic [ADDR_W-1:0]                 hb_addr,
    input  logic                              hb_rd,
    input  logic                              hb_wr,
    input  logic                              cfg_mode,
    input  logic                              swallow,
    input  logic [DATA_W-1:0]                 drv_rdata,
    input  logic [(1<<ADDR_W)-1:0][REG_W-1:0] view,
    output logic                              drv_rd,
    output logic                              drv_wr,
    output logic [DATA_W-1:0]                 hb_rdata
);

    localparam int PAD_W = DATA_W - REG_W;

    always_comb begin
        drv_rd   = hb_rd & ~hb_wr & ~cfg_mode;
        drv_wr   = hb_wr & ~cfg_mode & ~swallow;
        hb_rdata = cfg_mode ? {{PAD_W{1'b0}}, view[hb_addr]} : drv_rdata;
    end

endmodule

// File: rtl/cfg_trapdoor.sv
module cfg_trapdoor
    import cfg_trapdoor_pkg::*;
#(
    parameter int               ADDR_W       = 3,
    parameter int               DATA_W       = 16,
    parameter int               REG_W        = 8,
    parameter int               KNOCK_RD_OFF = 1,
    parameter int               KNOCK_WR_OFF = 2,
    parameter int               RD_TIM_OFF   = 0,
    parameter int               WR_TIM_OFF   = 1,
    parameter int               CTRL_OFF     = 3,
    parameter int               STRAP_OFF    = 5,
    parameter int               MISC_OFF     = 6,
    parameter logic [REG_W-1:0] UNLOCK_VAL   = 8'h03,
    parameter logic [REG_W-1:0] RELOCK_VAL   = 8'h83
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_pin,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic              hb_wide,
    input  logic              hb_rd,
    input  logic              hb_wr,
    input  logic [DATA_W-1:0] hb_wdata,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              drv_rd,
    output logic              drv_wr,
    input  logic [DATA_W-1:0] drv_rdata,
    output logic              cfg_mode,
    output logic [REG_W-1:0]  rd_timing,
    output logic [REG_W-1:0]  wr_timing,
    output logic [REG_W-1:0]  ctrl_reg,
    output logic [REG_W-1:0]  strap_reg,
    output logic [REG_W-1:0]  misc_reg
);

    localparam int          N_OFF     = 1 << ADDR_W;
    localparam int unsigned IMPL_MASK = (32'd1 << RD_TIM_OFF) | (32'd1 << WR_TIM_OFF)
                                      | (32'd1 << CTRL_OFF)   | (32'd1 << STRAP_OFF)
                                      | (32'd1 << MISC_OFF);

    logic [REG_W-1:0]            wbyte;
    logic                        swallow;
    logic                        hid_wr_en;
    logic [N_OFF-1:0][REG_W-1:0] view;
    logic                        wdata_hi_unused;

    assign wbyte           = hb_wdata[REG_W-1:0];
    assign wdata_hi_unused = ^hb_wdata[DATA_W-1:REG_W];
    assign hid_wr_en       = cfg_mode & hb_wr & ~hb_wide;

    cfg_knock_fsm #(
        .ADDR_W       (ADDR_W),
        .REG_W        (REG_W),
        .KNOCK_RD_OFF (KNOCK_RD_OFF),
        .KNOCK_WR_OFF (KNOCK_WR_OFF),
        .UNLOCK_VAL   (UNLOCK_VAL),
        .RELOCK_VAL   (RELOCK_VAL)
    ) i_knock (
        .clk      (clk),
        .rst      (rst),
        .hb_addr  (hb_addr),
        .hb_wide  (hb_wide),
        .hb_rd    (hb_rd),
        .hb_wr    (hb_wr),
        .wbyte    (wbyte),
        .cfg_mode (cfg_mode),
        .swallow  (swallow)
    );

    cfg_hidden_regs #(
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .STRAP_OFF (STRAP_OFF),
        .IMPL_MASK (IMPL_MASK)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .strap_pin (strap_pin),
        .wr_en     (hid_wr_en),
        .wr_addr   (hb_addr),
        .wbyte     (wbyte),
        .view      (view)
    );

    cfg_bus_steer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) i_steer (
        .hb_addr   (hb_addr),
        .hb_rd     (hb_rd),
        .hb_wr     (hb_wr),
        .cfg_mode  (cfg_mode),
        .swallow   (swallow),
        .drv_rdata (drv_rdata),
        .view      (view),
        .drv_rd    (drv_rd),
        .drv_wr    (drv_wr),
        .hb_rdata  (hb_rdata)
    );

    assign rd_timing = view[RD_TIM_OFF];
    assign wr_timing = view[WR_TIM_OFF];
    assign ctrl_reg  = view[CTRL_OFF];
    assign strap_reg = view[STRAP_OFF];
    assign misc_reg  = view[MISC_OFF];

endmodule

// File: rtl/cfg_trapdoor_chk.sv
module cfg_trapdoor_chk #(
    parameter int               ADDR_W       = 3,
    parameter int               DATA_W       = 16,
    parameter int               REG_W        = 8,
    parameter int               KNOCK_WR_OFF = 2,
    parameter int               RD_TIM_OFF   = 0,
    parameter logic [REG_W-1:0] UNLOCK_VAL   = 8'h03,
    parameter logic [REG_W-1:0] RELOCK_VAL   = 8'h83
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] hb_addr,
    input logic              hb_wide,
    input logic              hb_rd,
    input logic              hb_wr,
    input logic [DATA_W-1:0] hb_wdata,
    input logic [DATA_W-1:0] hb_rdata,
    input logic              drv_rd,
    input logic              drv_wr,
    input logic [DATA_W-1:0] drv_rdata,
    input logic              cfg_mode,
    input logic [REG_W-1:0]  rd_timing,
    input logic [REG_W-1:0]  strap_reg
);

    localparam logic [ADDR_W-1:0] WR_A  = ADDR_W'(KNOCK_WR_OFF);
    localparam logic [ADDR_W-1:0] TIM_A = ADDR_W'(RD_TIM_OFF);

    logic prev_rst_q;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
    end

    // R1
    always @(posedge clk) begin
        if (prev_rst_q === 1'b1 && rst === 1'b0) begin
            reset_state_chk: assert (!cfg_mode && rd_timing == '0 && strap_reg[REG_W-1:1] == '0);
        end
    end

    // R2
    unlock_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode) |-> $past(hb_wr && !hb_wide && hb_addr == WR_A
                                  && hb_wdata[REG_W-1:0] == UNLOCK_VAL));

    // R8
    relock_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_mode) |-> $past(hb_wr && !hb_wide && hb_addr == WR_A
                                  && hb_wdata[REG_W-1:0] == RELOCK_VAL));

    // R4
    pass_read_chk: assert property (@(posedge clk) disable iff (rst)
        (hb_rd && !hb_wr && !cfg_mode) |-> (drv_rd && hb_rdata == drv_rdata));

    // R10
    no_drive_open_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> (!drv_rd && !drv_wr));

    // R5
    timing_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && hb_wr && !hb_wide && hb_addr == TIM_A)
            |=> (rd_timing == $past(hb_wdata[REG_W-1:0])));

    // R9
    wide_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && hb_wr && hb_wide) |=> $stable(rd_timing));

    // R6
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_reg[0]));

endmodule

bind cfg_trapdoor cfg_trapdoor_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .REG_W        (REG_W),
    .KNOCK_WR_OFF (KNOCK_WR_OFF),
    .RD_TIM_OFF   (RD_TIM_OFF),
    .UNLOCK_VAL   (UNLOCK_VAL),
    .RELOCK_VAL   (RELOCK_VAL)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .hb_addr   (hb_addr),
    .hb_wide   (hb_wide),
    .hb_rd     (hb_rd),
    .hb_wr     (hb_wr),
    .hb_wdata  (hb_wdata),
    .hb_rdata  (hb_rdata),
    .drv_rd    (drv_rd),
    .drv_wr    (drv_wr),
    .drv_rdata (drv_rdata),
    .cfg_mode  (cfg_mode),
    .rd_timing (rd_timing),
    .strap_reg (strap_reg)
);

// File: tb/test_cfg_trapdoor.sv
module test_cfg_trapdoor;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 35;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        wide;
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [15:0] drdat;
        logic        x_drd;
        logic        x_dwr;
        logic [15:0] x_rdata;
        logic        x_cfg;
        logic [3:0]  req;
    } vec_t;

    // Fields: rd, wr, wide, addr, wdata, drive rdata, exp drv_rd, exp drv_wr,
    // exp host rdata (reads only), exp cfg_mode after the edge, requirement number.
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'hA5A5,1'b1,1'b0,16'hA5A5,1'b0,4'd4},  // R4
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h1234,1'b1,1'b0,16'h1234,1'b0,4'd4},  // R4
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd2},  // R2, R10
        '{1'b0,1'b1,1'b0,3'd0,16'h006B,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd5},  // R5
        '{1'b0,1'b1,1'b0,3'd1,16'h0056,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd5},  // R5
        '{1'b0,1'b1,1'b0,3'd3,16'h0085,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd5},  // R5
        '{1'b0,1'b1,1'b0,3'd6,16'h0001,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd5},  // R5
        '{1'b1,1'b0,1'b1,3'd0,16'h0000,16'hFFFF,1'b0,1'b0,16'h006B,1'b1,4'd7},  // R7
        '{1'b1,1'b0,1'b0,3'd1,16'h0000,16'hFFFF,1'b0,1'b0,16'h0056,1'b1,4'd7},  // R7
        '{1'b1,1'b0,1'b1,3'd6,16'h0000,16'hFFFF,1'b0,1'b0,16'h0001,1'b1,4'd7},  // R7
        '{1'b0,1'b1,1'b0,3'd4,16'h0077,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd9},  // R9
        '{1'b0,1'b1,1'b1,3'd0,16'h1111,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd9},  // R9
        '{1'b0,1'b1,1'b0,3'd2,16'h0055,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd9},  // R9
        '{1'b1,1'b0,1'b1,3'd0,16'h0000,16'hFFFF,1'b0,1'b0,16'h006B,1'b1,4'd9},  // R9
        '{1'b0,1'b1,1'b0,3'd2,16'h0083,16'h0000,1'b0,1'b0,16'h0000,1'b0,4'd8},  // R8, R10
        '{1'b1,1'b0,1'b1,3'd0,16'h0000,16'h0BAD,1'b1,1'b0,16'h0BAD,1'b0,4'd8},  // R8
        '{1'b0,1'b1,1'b0,3'd0,16'h0022,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd11}, // R11
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h1111,1'b1,1'b0,16'h1111,1'b0,4'd3},  // R3
        '{1'b1,1'b0,1'b0,3'd1,16'h0000,16'h2222,1'b1,1'b0,16'h2222,1'b0,4'd3},  // R3 byte read breaks
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd3},  // R3
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h3333,1'b1,1'b0,16'h3333,1'b0,4'd3},  // R3
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h4444,1'b1,1'b0,16'h4444,1'b0,4'd3},  // R3
        '{1'b0,1'b1,1'b0,3'd2,16'h0004,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd3},  // R3 wrong value
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd3},  // R3 lone 0x03
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h5555,1'b1,1'b0,16'h5555,1'b0,4'd3},  // R3
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h6666,1'b1,1'b0,16'h6666,1'b0,4'd3},  // R3
        '{1'b0,1'b1,1'b1,3'd2,16'h0003,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd3},  // R3 wrong width
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h7777,1'b1,1'b0,16'h7777,1'b0,4'd4},  // R4
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,16'h8888,1'b1,1'b0,16'h8888,1'b0,4'd4},  // R4
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd2},  // R2
        '{1'b1,1'b0,1'b1,3'd0,16'h0000,16'hFFFF,1'b0,1'b0,16'h006B,1'b1,4'd11}, // R11, R8 kept
        '{1'b0,1'b1,1'b0,3'd5,16'h00FE,16'h0000,1'b0,1'b0,16'h0000,1'b1,4'd6},  // R6
        '{1'b1,1'b0,1'b1,3'd5,16'h0000,16'hFFFF,1'b0,1'b0,16'h00FF,1'b1,4'd6},  // R6
        '{1'b1,1'b0,1'b1,3'd7,16'h0000,16'hFFFF,1'b0,1'b0,16'h0000,1'b1,4'd7},  // R7
        '{1'b0,1'b1,1'b0,3'd2,16'h0083,16'h0000,1'b0,1'b0,16'h0000,1'b0,4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        strap_pin;
    logic [2:0]  hb_addr;
    logic        hb_wide;
    logic        hb_rd;
    logic        hb_wr;
    logic [15:0] hb_wdata;
    logic [15:0] hb_rdata;
    logic        drv_rd;
    logic        drv_wr;
    logic [15:0] drv_rdata;
    logic        cfg_mode;
    logic [7:0]  rd_timing;
    logic [7:0]  wr_timing;
    logic [7:0]  ctrl_reg;
    logic [7:0]  strap_reg;
    logic [7:0]  misc_reg;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_trapdoor i_cfg_trapdoor (
        .clk       (clk),
        .rst       (rst),
        .strap_pin (strap_pin),
        .hb_addr   (hb_addr),
        .hb_wide   (hb_wide),
        .hb_rd     (hb_rd),
        .hb_wr     (hb_wr),
        .hb_wdata  (hb_wdata),
        .hb_rdata  (hb_rdata),
        .drv_rd    (drv_rd),
        .drv_wr    (drv_wr),
        .drv_rdata (drv_rdata),
        .cfg_mode  (cfg_mode),
        .rd_timing (rd_timing),
        .wr_timing (wr_timing),
        .ctrl_reg  (ctrl_reg),
        .strap_reg (strap_reg),
        .misc_reg  (misc_reg)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_bus();
        hb_rd     = 1'b0;
        hb_wr     = 1'b0;
        hb_wide   = 1'b0;
        hb_addr   = '0;
        hb_wdata  = '0;
        drv_rdata = '0;
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        idle_bus();
        rst       = 1'b1;
        strap_pin = pin;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic run_vec(input int i);
        string tag;
        tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
        @(negedge clk);
        hb_rd     = VECS[i].rd;
        hb_wr     = VECS[i].wr;
        hb_wide   = VECS[i].wide;
        hb_addr   = VECS[i].addr;
        hb_wdata  = VECS[i].wdata;
        drv_rdata = VECS[i].drdat;
        #1;
        check(tag, "drv_rd", 32'(drv_rd), 32'(VECS[i].x_drd));
        check(tag, "drv_wr", 32'(drv_wr), 32'(VECS[i].x_dwr));
        if (VECS[i].rd) check(tag, "hb_rdata", 32'(hb_rdata), 32'(VECS[i].x_rdata));
        @(posedge clk);
        #1;
        check(tag, "cfg_mode", 32'(cfg_mode), 32'(VECS[i].x_cfg));
        idle_bus();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_bus();
        rst       = 1'b1;
        strap_pin = 1'b1;
        do_reset(1'b1);

        // R1: locked, hidden registers cleared; R6: strap captured as 1
        check("R1", "cfg_mode", 32'(cfg_mode), 32'h0);
        check("R1", "rd_timing", 32'(rd_timing), 32'h0);
        check("R1", "wr_timing", 32'(wr_timing), 32'h0);
        check("R1", "ctrl_reg", 32'(ctrl_reg), 32'h0);
        check("R1", "misc_reg", 32'(misc_reg), 32'h0);
        check("R6", "strap_reg", 32'(strap_reg), 32'h01);

        // R6: pin changes after reset must not reach the register
        strap_pin = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            run_vec(i);
        end

        // R5 output ports after the table; R6 strap bits kept after relock
        #1;
        check("R5", "rd_timing", 32'(rd_timing), 32'h6B);
        check("R5", "wr_timing", 32'(wr_timing), 32'h56);
        check("R5", "ctrl_reg", 32'(ctrl_reg), 32'h85);
        check("R5", "misc_reg", 32'(misc_reg), 32'h01);
        check("R6", "strap_reg", 32'(strap_reg), 32'hFF);

        // R1 second reset with strap low: all cleared, strap bit follows pin
        do_reset(1'b0);
        check("R1", "cfg_mode", 32'(cfg_mode), 32'h0);
        check("R1", "rd_timing", 32'(rd_timing), 32'h0);
        check("R1", "misc_reg", 32'(misc_reg), 32'h0);
        check("R6", "strap_reg", 32'(strap_reg), 32'h00);

        // R3: a pattern cut off by reset does not carry over
        @(negedge clk);
        hb_rd = 1'b1; hb_wide = 1'b1; hb_addr = 3'd1;
        @(negedge clk);
        idle_bus();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hb_rd = 1'b1; hb_wide = 1'b1; hb_addr = 3'd1;
        @(negedge clk);
        hb_rd = 1'b0; hb_wr = 1'b1; hb_wide = 1'b0; hb_addr = 3'd2; hb_wdata = 16'h0003;
        #1;
        check("R3", "drv_wr", 32'(drv_wr), 32'h1);
        @(posedge clk);
        #1;
        check("R3", "cfg_mode", 32'(cfg_mode), 32'h0);
        idle_bus();

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule